// File: doc/BRIEF.md
# Conditional Select-Increment Execute Stage

This block is a one-stage execute unit for a single integer operation: pick one register operand when a flag condition is met, or else take a second register operand plus one. It receives a 32-bit instruction word with a valid strobe and the four condition flags (negative, zero, carry, overflow). It drives two register-file read addresses and gets the read data back in the same cycle. One clock later it presents the result, the destination index, a write enable and a hint that marks two common special forms of the word.

The word is accepted only when its fixed opcode bits match. It then yields a field for operand width (32 or 64 bits), two source indices, a condition code and a destination index. Index 31 stands for a hard zero register. On reads it supplies zero, whatever the register file returns. As a destination it suppresses the write. In 32-bit mode the sources are cut to their low half and the upper half of the result is cleared.

Top module: `selinc_exec_unit`

## Requirements
- R1: `out_valid` rises one cycle after a cycle with `in_valid` high and a word whose bits 30:21 are 0011010100 and whose bits 11:10 are 01. After any other word, or with `in_valid` low, `out_valid` is low.
- R2: When the condition holds, `out_result` equals the operand addressed by bits 9:5.
- R3: When the condition fails, `out_result` equals the operand addressed by bits 20:16 plus one, wrapping at the operand width.
- R4: The condition is bits 15:12. Bits 15:13 pick the test: 000 Z, 001 C, 010 N, 011 V, 100 C and not Z, 101 N equals V, 110 N equals V and not Z, 111 always. Bit 12 set inverts the test, except for code 1111, which also always holds.
- R5: Bit 31 clear selects 32-bit mode. Only the low 32 bits of each operand are used, and `out_result[63:32]` is zero. Bit 31 set selects 64-bit mode.
- R6: A source index of 31 supplies zero, whatever the value on the read-data input.
- R7: `out_dst` equals bits 4:0. `out_wen` is high exactly when `out_valid` is high and the destination index is not 31.
- R8: `out_alias` is 2'b01 (increment form) when both source indices are equal, neither is 31, and the condition is not 1110 or 1111.
- R9: `out_alias` is 2'b10 (set form) when both source indices are 31 and the condition is not 1110 or 1111. In every other case it is 2'b00. In the set form the result is 0 or 1.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_wen` at the next clock edge.
- R11: `rf_addr_a` follows bits 9:5 and `rf_addr_b` follows bits 20:16 of `instr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| rf_addr_a | output | 5 | Read address of the selected operand |
| rf_addr_b | output | 5 | Read address of the incremented operand |
| rf_data_a | input | 64 | Read data for `rf_addr_a` |
| rf_data_b | input | 64 | Read data for `rf_addr_b` |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Registered result |
| out_dst | output | 5 | Registered destination index |
| out_wen | output | 1 | Registered register-file write enable |
| out_alias | output | 2 | Special-form hint: 00 none, 01 increment, 10 set |

## Verification
Every one of the sixteen condition codes is tried under all sixteen flag combinations in both widths. This separates each base test from its inverse and shows that the always codes ignore the flags. Distinct operands that are not all-ones, one of them with a nonzero upper half, show which source was chosen and whether 32-bit truncation happened. All-ones operands in both widths show the wrap of the increment. Index-31 words, with garbage driven on the read-data inputs, show the zero-register reads, the write suppression and the alias split. Single-bit corruptions of every opcode bit, plus random words, show that the match rejects what it should and accepts what it should.

// File: rtl/selinc_pkg.sv
package selinc_pkg;

  localparam int IW     = 32;
  localparam int IDX_W  = 5;
  localparam int COND_W = 4;

  localparam logic [9:0] OPC_HIGH = 10'b0011010100;
  localparam logic [1:0] OPC_LOW  = 2'b01;

  typedef enum logic [1:0] {
    FORM_PLAIN = 2'b00,
    FORM_INC   = 2'b01,
    FORM_SET   = 2'b10
  } form_e;

  typedef struct packed {
    logic              wide;
    logic [IDX_W-1:0]  sel_idx;
    logic [IDX_W-1:0]  inc_idx;
    logic [COND_W-1:0] cond;
    logic [IDX_W-1:0]  dst_idx;
  } word_fields_t;

endpackage

// File: rtl/selinc_decode.sv
module selinc_decode
  import selinc_pkg::*;
(
  input  logic [IW-1:0] instr,
  output logic          match,
  output word_fields_t  fields,
  output form_e         form
);

  localparam logic [IDX_W-1:0] ZREG = {IDX_W{1'b1}};

  logic opc_high_ok;
  logic opc_low_ok;
  logic cond_plain;
  logic a_is_z;
  logic b_is_z;

  always_comb begin
    opc_high_ok = (instr[30:21] == OPC_HIGH);
    opc_low_ok  = (instr[11:10] == OPC_LOW);
    match       = opc_high_ok && opc_low_ok;
  end

  always_comb begin
    fields.wide    = instr[31];
    fields.inc_idx = instr[20:16];
    fields.cond    = instr[15:12];
    fields.sel_idx = instr[9:5];
    fields.dst_idx = instr[4:0];
  end

  always_comb begin
    cond_plain = (fields.cond[COND_W-1:1] != 3'b111);
    a_is_z     = (fields.sel_idx == ZREG);
    b_is_z     = (fields.inc_idx == ZREG);
    form       = FORM_PLAIN;
    if (cond_plain) begin
      if (a_is_z && b_is_z)
        form = FORM_SET;
      else if (!a_is_z && !b_is_z && (fields.sel_idx == fields.inc_idx))
        form = FORM_INC;
    end
  end

endmodule

// File: rtl/selinc_cond_eval.sv
module selinc_cond_eval
  import selinc_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              fn,
  input  logic              fz,
  input  logic              fc,
  input  logic              fv,
  output logic              holds
);

  logic base;
  logic n_eq_v;

  always_comb begin
    n_eq_v = (fn == fv);
    unique case (cond[COND_W-1:1])
      3'd0:    base = fz;
      3'd1:    base = fc;
      3'd2:    base = fn;
      3'd3:    base = fv;
      3'd4:    base = fc && !fz;
      3'd5:    base = n_eq_v;
      3'd6:    base = n_eq_v && !fz;
      default: base = 1'b1;
    endcase
    if (cond[0] && (cond != 4'b1111))
      holds = !base;
    else
      holds = base;
  end

endmodule

// File: rtl/selinc_datapath.sv
module selinc_datapath #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              wide,
  input  logic              take_sel,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [IDX_W-1:0]  inc_idx,
  input  logic [DATA_W-1:0] sel_data,
  input  logic [DATA_W-1:0] inc_data,
  output logic [DATA_W-1:0] result
);

  localparam int HALF = DATA_W / 2;
  localparam logic [IDX_W-1:0] ZREG = {IDX_W{1'b1}};

  logic [DATA_W-1:0] op_sel;
  logic [DATA_W-1:0] op_inc;
  logic [DATA_W-1:0] bumped;
  logic [DATA_W-1:0] chosen;

  always_comb begin
    op_sel = (sel_idx == ZREG) ? '0 : sel_data;
    op_inc = (inc_idx == ZREG) ? '0 : inc_data;
    if (!wide) begin
      op_sel[DATA_W-1:HALF] = '0;
      op_inc[DATA_W-1:HALF] = '0;
    end
  end

  always_comb begin
    bumped = op_inc + DATA_W'(1);
    chosen = take_sel ? op_sel : bumped;
    result = chosen;
    if (!wide)
      result[DATA_W-1:HALF] = '0;
  end

endmodule

// File: rtl/selinc_exec_unit.sv
module selinc_exec_unit
  import selinc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic [4:0]        rf_addr_a,
  output logic [4:0]        rf_addr_b,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [4:0]        out_dst,
  output logic              out_wen,
  output logic [1:0]        out_alias
);

  localparam int HALF = DATA_W / 2;
  localparam logic [IDX_W-1:0] ZREG = {IDX_W{1'b1}};

  logic              match;
  word_fields_t      fld;
  form_e             form;
  logic              cond_ok;
  logic [DATA_W-1:0] res_c;
  logic              accept;

  selinc_decode u_dec (
    .instr  (instr),
    .match  (match),
    .fields (fld),
    .form   (form)
  );

  selinc_cond_eval u_cond (
    .cond  (fld.cond),
    .fn    (flag_n),
    .fz    (flag_z),
    .fc    (flag_c),
    .fv    (flag_v),
    .holds (cond_ok)
  );

  selinc_datapath #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .wide     (fld.wide),
    .take_sel (cond_ok),
    .sel_idx  (fld.sel_idx),
    .inc_idx  (fld.inc_idx),
    .sel_data (rf_data_a),
    .inc_data (rf_data_b),
    .result   (res_c)
  );

  assign rf_addr_a = fld.sel_idx;
  assign rf_addr_b = fld.inc_idx;
  assign accept    = in_valid && match;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
    end else begin
      out_valid <= accept;
      out_wen   <= accept && (fld.dst_idx != ZREG);
    end
  end

  always_ff @(posedge clk) begin
    out_result <= res_c;
    out_dst    <= fld.dst_idx;
    out_alias  <= match ? form : FORM_PLAIN;
  end

  // R10
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_wen));

  // R1
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  wen_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_valid && (out_dst != ZREG)));

  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !instr[31]) |=> (out_result[DATA_W-1:HALF] == '0));

  // R9
  set_form_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_alias == FORM_SET)) |-> (out_result <= DATA_W'(1)));

  // R11
  addr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_addr_a == instr[9:5]) && (rf_addr_b == instr[20:16]));

endmodule

// File: tb/tb_selinc_exec_unit.sv
`timescale 1ns/1ps
module tb_selinc_exec_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr;
  logic        fn, fz, fc, fv;
  logic [4:0]  ra, rb;
  logic [63:0] da, db;
  logic        o_valid, o_wen;
  logic [63:0] o_res;
  logic [4:0]  o_dst;
  logic [1:0]  o_alias;

  int total = 0;
  int bad   = 0;
  logic [63:0] regs [0:31];

  always #2.5 clk = ~clk;

  assign da = regs[ra];
  assign db = regs[rb];

  selinc_exec_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .rf_addr_a(ra), .rf_addr_b(rb), .rf_data_a(da), .rf_data_b(db),
    .out_valid(o_valid), .out_result(o_res), .out_dst(o_dst),
    .out_wen(o_wen), .out_alias(o_alias)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic sf, input logic [4:0] rm,
                                     input logic [3:0] c, input logic [4:0] rn,
                                     input logic [4:0] rd);
    return {sf, 10'b0011010100, rm, c, 2'b01, rn, rd};
  endfunction

  function automatic bit cond_ref(input logic [3:0] c, input logic n,
                                  input logic z, input logic cy, input logic v);
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !(cy && !z);
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return !(!z && (n == v));
      default: return 1'b1;
    endcase
  endfunction

  task automatic run(input logic [31:0] w, input logic [3:0] fl, input logic iv);
    logic        is_op, sf, holds;
    logic [4:0]  rn, rm, rd;
    logic [63:0] a, b, er;
    logic [1:0]  ea;
    string       tg;
    @(negedge clk);
    instr = w; in_valid = iv; {fn, fz, fc, fv} = fl;
    #1;
    // R11
    check(ra == w[9:5] && rb == w[20:16], "R11", "read addresses",
          {ra, rb}, {w[9:5], w[20:16]});
    is_op = iv && (w[30:21] == 10'b0011010100) && (w[11:10] == 2'b01);
    sf = w[31]; rm = w[20:16]; rn = w[9:5]; rd = w[4:0];
    holds = cond_ref(w[15:12], fl[3], fl[2], fl[1], fl[0]);
    a = (rn == 5'd31) ? 64'd0 : regs[rn];
    b = (rm == 5'd31) ? 64'd0 : regs[rm];
    if (!sf) begin a[63:32] = '0; b[63:32] = '0; end
    er = holds ? a : b + 64'd1;
    if (!sf) er[63:32] = '0;
    ea = 2'b00;
    if (w[15:13] != 3'b111) begin
      if (rn == 5'd31 && rm == 5'd31) ea = 2'b10;
      else if (rn != 5'd31 && rm != 5'd31 && rn == rm) ea = 2'b01;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check(o_valid == is_op, "R1", "valid", 64'(o_valid), 64'(is_op));
    if (is_op) begin
      tg = holds ? "R2 R4" : "R3 R4";
      if (!sf) tg = {tg, " R5"};
      if (rn == 5'd31 || rm == 5'd31) tg = {tg, " R6"};
      check(o_res == er, tg, "result", o_res, er);
      // R7
      check(o_dst == rd && o_wen == (rd != 5'd31), "R7", "dst/wen",
            {o_dst, o_wen}, {rd, rd != 5'd31});
      check(o_alias == ea, (ea == 2'b01) ? "R8" : "R9", "alias",
            64'(o_alias), 64'(ea));
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; {fn, fz, fc, fv} = '0;
    for (int i = 0; i < 31; i++) regs[i] = {$urandom, $urandom} | 64'h1_0000_0000;
    regs[31] = 64'hDEAD_BEEF_CAFE_F00D;
    regs[5]  = '1;
    regs[6]  = 64'h1234_5678_FFFF_FFFF;
    regs[7]  = 64'h0000_0003_0000_0010;
    regs[8]  = 64'h0000_0009_0000_0020;
    repeat (3) @(posedge clk);
    #1;
    // R10
    check(!o_valid && !o_wen, "R10", "reset state", {o_valid, o_wen}, 0);
    @(negedge clk); rst = 1'b0;

    // R4 sweep: every condition, every flag set, both widths
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 16; c++)
        for (int f = 0; f < 16; f++)
          run(mk(s[0], 5'd8, c[3:0], 5'd7, 5'd3), f[3:0], 1'b1);

    // R3 wraparound in both widths
    run(mk(1'b1, 5'd5, 4'd0, 5'd7, 5'd1), 4'b0000, 1'b1);
    run(mk(1'b0, 5'd5, 4'd0, 5'd7, 5'd1), 4'b0000, 1'b1);
    run(mk(1'b0, 5'd6, 4'd0, 5'd7, 5'd1), 4'b0000, 1'b1);
    run(mk(1'b1, 5'd6, 4'd0, 5'd7, 5'd1), 4'b0000, 1'b1);

    // R6 R9 zero register and set form
    for (int c = 0; c < 16; c++) begin
      run(mk(1'b1, 5'd31, c[3:0], 5'd31, 5'd2), 4'b0100, 1'b1);
      run(mk(1'b1, 5'd31, c[3:0], 5'd31, 5'd2), 4'b0000, 1'b1);
    end
    run(mk(1'b1, 5'd31, 4'd1, 5'd4, 5'd2), 4'b0100, 1'b1);
    run(mk(1'b1, 5'd31, 4'd0, 5'd4, 5'd2), 4'b0100, 1'b1);
    run(mk(1'b1, 5'd4, 4'd0, 5'd31, 5'd2), 4'b0100, 1'b1);
    // R7 destination 31
    run(mk(1'b1, 5'd4, 4'd0, 5'd9, 5'd31), 4'b0000, 1'b1);
    // R8 increment form and its exclusions
    for (int c = 0; c < 16; c++) run(mk(1'b0, 5'd9, c[3:0], 5'd9, 5'd2), 4'b0010, 1'b1);
    run(mk(1'b0, 5'd9, 4'd3, 5'd10, 5'd2), 4'b0010, 1'b1);

    // R1 single-bit opcode corruptions and idle strobe
    for (int b = 21; b <= 30; b++)
      run(mk(1'b1, 5'd4, 4'd0, 5'd9, 5'd2) ^ (32'd1 << b), 4'b0000, 1'b1);
    run(mk(1'b1, 5'd4, 4'd0, 5'd9, 5'd2) ^ (32'd1 << 10), 4'b0000, 1'b1);
    run(mk(1'b1, 5'd4, 4'd0, 5'd9, 5'd2) ^ (32'd1 << 11), 4'b0000, 1'b1);
    run(mk(1'b1, 5'd4, 4'd0, 5'd9, 5'd2), 4'b0000, 1'b0);

    // random words, half forced to match
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k[0]) w = mk(w[31], w[20:16], w[15:12], w[9:5], w[4:0]);
      run(w, 4'($urandom), 1'b1);
    end

    // R10 reset while a word is presented
    @(negedge clk);
    instr = mk(1'b1, 5'd4, 4'd0, 5'd9, 5'd2); in_valid = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    check(!o_valid && !o_wen, "R10", "reset with input", {o_valid, o_wen}, 0);
    rst = 1'b0; in_valid = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule